// File: doc/BRIEF.md
# Two-Pass Prime-Factor DFT Engine

This block computes a discrete Fourier transform of length N = N1 × N2, where the two factors are coprime. The work is split into two passes of short transforms. Because the factors share no divisor, the index mapping absorbs all rotation, so nothing is multiplied between the passes. One shared complex multiply-accumulate datapath serves every short transform size. A run-time length code picks the factor pair, which selects the transform size in each pass and the coefficient set.

Two small working memories hold the data. The primary memory is loaded by the host with samples already in prime-factor input order. Pass one reads it in address order and runs N2 short transforms of N1 points. Results land in the secondary memory in address order. Pass two reads the secondary memory with stride N1 and runs N1 short transforms of N2 points. It writes each result back into the primary memory at its natural frequency index, where the host reads it once the run has finished.

Top module: `pfa_dft_engine`

## Requirements
- R1: When idle, a start pulse with len_sel code 0, 1 or 2 begins a run with (N1, N2) = (2, 3), (4, 3) or (3, 5), so N = 6, 12 or 15. `busy` is high in the cycle after the start edge.
- R2: Before a run, primary memory address n2·N1 + n1 must hold sample x[(N2·n1 + N1·n2) mod N], for 0 ≤ n1 < N1 and 0 ≤ n2 < N2.
- R3: After a run, primary memory address k holds X[k] = Σ x[n]·e^(−j2πnk/N) for 0 ≤ k < N, with real and imaginary parts each within ±16 of the exact value, as 22-bit signed numbers.
- R4: `busy` stays high for exactly N1·N2·(N1+N2) cycles (30, 84 or 120). `done` is high for exactly one cycle, which is the first cycle with `busy` low.
- R5: A start pulse while busy is ignored. The length in use, the run time and the results are unchanged.
- R6: A start pulse with len_sel code 3 is ignored. `busy` and `done` stay low and the memory contents are unchanged.
- R7: A host load (`ld_en`) while busy is ignored. The addressed location keeps its prior content.
- R8: While reset is asserted, and after it is released with no start, `busy` and `done` are low.
- R9: While idle, `rd_re`/`rd_im` show primary memory at `rd_addr` without a clock. Loaded 16-bit samples read back sign-extended to 22 bits.
- R10: Full-scale inputs, including every sample at −32768, complete without overflow and meet R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts a run when idle |
| len_sel | input | 2 | Length code: 0→6, 1→12, 2→15, 3 unsupported |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run has finished |
| ld_en | input | 1 | Host write strobe into primary memory (idle only) |
| ld_addr | input | 4 | Host write address |
| ld_re | input | 16 | Host sample, real part, signed |
| ld_im | input | 16 | Host sample, imaginary part, signed |
| rd_addr | input | 4 | Host read address |
| rd_re | output | 22 | Primary memory real part at rd_addr, signed |
| rd_im | output | 22 | Primary memory imaginary part at rd_addr, signed |

## Verification
Each length is driven with several input patterns, and each pattern separates a different class of fault:
- A unit impulse at sample zero must give a flat spectrum. Any error in the output address mapping or in pass sequencing therefore shows as a single misplaced bin.
- A constant full-scale negative input puts all its energy in bin zero, which exposes overflow and sign-extension faults.
- An alternating extreme pattern stresses every coefficient at its largest magnitude.
- Seeded random complex data is compared against a direct reference transform, which catches coefficient sign or value errors that the structured patterns can hide.

Start and load pulses during a run, and a start with the unsupported code, confirm that nothing leaks into the length in use or into memory.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

  // fraction bits of the short-transform coefficients
  localparam int CFRAC = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_P1, ST_P2} pfa_st_e;

  // first factor (pass-one transform size)
  function automatic int fac1(logic [1:0] c);
    case (c)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 3;
    endcase
  endfunction

  // second factor (pass-two transform size)
  function automatic int fac2(logic [1:0] c);
    case (c)
      2'd0, 2'd1: return 3;
      default:    return 5;
    endcase
  endfunction

  // CRT weights: a1 = N2*(N2^-1 mod N1), a2 = N1*(N1^-1 mod N2)
  function automatic int crt_a1(logic [1:0] c);
    case (c)
      2'd0:    return 3;
      2'd1:    return 9;
      default: return 10;
    endcase
  endfunction

  function automatic int crt_a2(logic [1:0] c);
    case (c)
      2'd0, 2'd1: return 4;
      default:    return 6;
    endcase
  endfunction

  function automatic int crt_pos(logic [1:0] c, int k1, int k2);
    return (crt_a1(c) * k1 + crt_a2(c) * k2) % (fac1(c) * fac2(c));
  endfunction

  // real part of exp(-j*2*pi*i/m), scaled by 2^CFRAC
  function automatic int w_re(int m, int i);
    case (m)
      2: return (i == 0) ? 65536 : -65536;
      3: return (i == 0) ? 65536 : -32768;
      4: return (i == 0) ? 65536 : ((i == 2) ? -65536 : 0);
      5: return (i == 0) ? 65536 : ((i == 1 || i == 4) ? 20252 : -53020);
      default: return 65536;
    endcase
  endfunction

  // imaginary part of exp(-j*2*pi*i/m), scaled by 2^CFRAC
  function automatic int w_im(int m, int i);
    case (m)
      3: return (i == 1) ? -56756 : ((i == 2) ? 56756 : 0);
      4: return (i == 1) ? -65536 : ((i == 3) ? 65536 : 0);
      5: case (i)
           1:       return -62328;
           2:       return -38521;
           3:       return 38521;
           4:       return 62328;
           default: return 0;
         endcase
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pfa_ram.sv
module pfa_ram #(
  parameter int DEPTH = 15,
  parameter int AW    = 4,
  parameter int W     = 44
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];

endmodule

// File: rtl/pfa_seq.sv
module pfa_seq
  import pfa_pkg::*;
#(
  parameter int AW  = 4,
  parameter int CNW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     len_sel,
  output logic           busy,
  output logic           done,
  output logic           pass2,
  output logic           mac_first,
  output logic [CNW-1:0] radix,
  output logic [CNW-1:0] tw_idx,
  output logic [AW-1:0]  rd_addr,
  output logic [AW-1:0]  wr_addr,
  output logic           wr_en
);

  pfa_st_e        st, st_n;
  logic [1:0]     sel, sel_n;
  logic [CNW-1:0] g, g_n, k, k_n, m, m_n, tw, tw_n;
  logic           done_n;
  logic [CNW-1:0] grp;
  logic           last_m, last_k, last_g, go, cnt_en;
  logic [CNW:0]   tw_sum;
  logic [CNW-1:0] tw_wrap;

  assign go     = (st == ST_IDLE) && start && (len_sel != 2'd3);
  assign cnt_en = go || (st != ST_IDLE);

  always_comb begin
    radix   = (st == ST_P1) ? CNW'(fac1(sel)) : CNW'(fac2(sel));
    grp     = (st == ST_P1) ? CNW'(fac2(sel)) : CNW'(fac1(sel));
    last_m  = (m == radix - 1'b1);
    last_k  = (k == radix - 1'b1);
    last_g  = (g == grp - 1'b1);
    tw_sum  = {1'b0, tw} + {1'b0, k};
    tw_wrap = (tw_sum >= {1'b0, radix}) ? CNW'(tw_sum - {1'b0, radix}) : CNW'(tw_sum);
  end

  // next-state
  always_comb begin
    st_n = st; sel_n = sel; g_n = g; k_n = k; m_n = m; tw_n = tw; done_n = 1'b0;
    case (st)
      ST_IDLE: begin
        if (go) begin
          sel_n = len_sel; st_n = ST_P1;
          g_n = '0; k_n = '0; m_n = '0; tw_n = '0;
        end
      end
      default: begin
        if (last_m) begin
          m_n = '0; tw_n = '0;
          if (last_k) begin
            k_n = '0;
            if (last_g) begin
              g_n = '0;
              if (st == ST_P1) st_n = ST_P2;
              else begin st_n = ST_IDLE; done_n = 1'b1; end
            end else g_n = g + 1'b1;
          end else k_n = k + 1'b1;
        end else begin
          m_n = m + 1'b1; tw_n = tw_wrap;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sel <= '0; done <= 1'b0;
      g <= '0; k <= '0; m <= '0; tw <= '0;
    end else begin
      done <= done_n;
      if (cnt_en) begin
        st <= st_n; sel <= sel_n;
        g <= g_n; k <= k_n; m <= m_n; tw <= tw_n;
      end
    end
  end

  // addressing: pass one reads groups in address order, pass two with stride N1
  always_comb begin
    busy      = (st != ST_IDLE);
    pass2     = (st == ST_P2);
    mac_first = (m == '0);
    tw_idx    = tw;
    wr_en     = busy && last_m;
    if (st == ST_P2) begin
      rd_addr = AW'(int'(m) * int'(grp) + int'(g));
      wr_addr = AW'(crt_pos(sel, int'(g), int'(k)));
    end else begin
      rd_addr = AW'(int'(g) * int'(radix) + int'(m));
      wr_addr = AW'(int'(g) * int'(radix) + int'(k));
    end
  end

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len_sel != 2'd3) |=> busy);
  a_r6_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len_sel == 2'd3) |=> (!busy && !done));
  a_r5_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(sel)));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(wr_en) && $past(pass2)));
  a_r3_tw_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tw < radix && m < radix && k < radix));

endmodule

// File: rtl/pfa_cmac.sv
module pfa_cmac
  import pfa_pkg::*;
#(
  parameter int OW   = 22,
  parameter int CW   = 18,
  parameter int CNW  = 3,
  parameter int FRAC = CFRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic [CNW-1:0]       radix,
  input  logic [CNW-1:0]       tw_idx,
  input  logic signed [OW-1:0] x_re,
  input  logic signed [OW-1:0] x_im,
  output logic signed [OW-1:0] y_re,
  output logic signed [OW-1:0] y_im
);

  localparam int PW  = OW + CW + 1;
  localparam int ACW = PW + 3;

  logic signed [CW-1:0]  c_re, c_im;
  logic signed [PW-1:0]  pr_re, pr_im;
  logic signed [ACW-1:0] acc_re, acc_im, sum_re, sum_im, sh_re, sh_im;

  assign c_re = CW'(w_re(int'(radix), int'(tw_idx)));
  assign c_im = CW'(w_im(int'(radix), int'(tw_idx)));

  assign pr_re = PW'(x_re) * PW'(c_re) - PW'(x_im) * PW'(c_im);
  assign pr_im = PW'(x_re) * PW'(c_im) + PW'(x_im) * PW'(c_re);

  assign sum_re = (first ? ACW'(0) : acc_re) + ACW'(pr_re);
  assign sum_im = (first ? ACW'(0) : acc_im) + ACW'(pr_im);

  // round to nearest, drop coefficient fraction
  assign sh_re = (sum_re + (ACW'(1) <<< (FRAC - 1))) >>> FRAC;
  assign sh_im = (sum_im + (ACW'(1) <<< (FRAC - 1))) >>> FRAC;
  assign y_re  = OW'(sh_re);
  assign y_im  = OW'(sh_im);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (en) begin
      acc_re <= sum_re;
      acc_im <= sum_im;
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((sh_re[ACW-1:OW-1] == '0 || sh_re[ACW-1:OW-1] == '1) &&
            (sh_im[ACW-1:OW-1] == '0 || sh_im[ACW-1:OW-1] == '1)));

endmodule

// File: rtl/pfa_dft_engine.sv
module pfa_dft_engine #(
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int GW   = 3,
  parameter int MAXN = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [1:0]                   len_sel,
  output logic                         busy,
  output logic                         done,
  input  logic                         ld_en,
  input  logic [$clog2(MAXN)-1:0]      ld_addr,
  input  logic signed [DW-1:0]         ld_re,
  input  logic signed [DW-1:0]         ld_im,
  input  logic [$clog2(MAXN)-1:0]      rd_addr,
  output logic signed [DW+2*GW-1:0]    rd_re,
  output logic signed [DW+2*GW-1:0]    rd_im
);

  localparam int AW  = $clog2(MAXN);
  localparam int MW  = DW + GW;
  localparam int OW  = DW + 2 * GW;
  localparam int CNW = 3;

  logic [1:0] rst_q;
  logic       rst_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  logic           pass2, mac_first, eng_we;
  logic [CNW-1:0] radix, tw_idx;
  logic [AW-1:0]  eng_ra, eng_wa;

  pfa_seq #(.AW(AW), .CNW(CNW)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .len_sel(len_sel),
    .busy(busy), .done(done), .pass2(pass2), .mac_first(mac_first),
    .radix(radix), .tw_idx(tw_idx), .rd_addr(eng_ra), .wr_addr(eng_wa),
    .wr_en(eng_we)
  );

  logic                 m1_we, m2_we;
  logic [AW-1:0]        m1_wa, m1_ra;
  logic [2*OW-1:0]      m1_wd, m1_rd;
  logic [2*MW-1:0]      m2_wd, m2_rd;
  logic signed [OW-1:0] x_re, x_im, y_re, y_im;

  // host owns primary memory only while idle
  assign m1_we = busy ? (eng_we && pass2) : ld_en;
  assign m1_wa = busy ? eng_wa : ld_addr;
  assign m1_wd = busy ? {y_re, y_im} : {OW'(ld_re), OW'(ld_im)};
  assign m1_ra = busy ? eng_ra : rd_addr;

  assign m2_we = eng_we && !pass2;
  assign m2_wd = {MW'(y_re), MW'(y_im)};

  pfa_ram #(.DEPTH(MAXN), .AW(AW), .W(2*OW)) u_mem1 (
    .clk(clk), .we(m1_we), .wa(m1_wa), .wd(m1_wd), .ra(m1_ra), .rd(m1_rd)
  );

  pfa_ram #(.DEPTH(MAXN), .AW(AW), .W(2*MW)) u_mem2 (
    .clk(clk), .we(m2_we), .wa(eng_wa), .wd(m2_wd), .ra(eng_ra), .rd(m2_rd)
  );

  assign x_re = pass2 ? OW'($signed(m2_rd[2*MW-1:MW])) : $signed(m1_rd[2*OW-1:OW]);
  assign x_im = pass2 ? OW'($signed(m2_rd[MW-1:0]))    : $signed(m1_rd[OW-1:0]);

  pfa_cmac #(.OW(OW), .CW(CW), .CNW(CNW)) u_mac (
    .clk(clk), .rst_n(rst_s), .en(busy), .first(mac_first),
    .radix(radix), .tw_idx(tw_idx), .x_re(x_re), .x_im(x_im),
    .y_re(y_re), .y_im(y_im)
  );

  assign rd_re = $signed(m1_rd[2*OW-1:OW]);
  assign rd_im = $signed(m1_rd[OW-1:0]);

  a_r10_mid_fit: assert property (@(posedge clk) disable iff (!rst_s)
    m2_we |-> ((y_re[OW-1:MW-1] == '0 || y_re[OW-1:MW-1] == '1) &&
               (y_im[OW-1:MW-1] == '0 || y_im[OW-1:MW-1] == '1)));
  a_r7_host_blocked: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && ld_en && !(eng_we && pass2)) |=> $stable(u_mem1.mem[$past(ld_addr)]));

endmodule

// File: tb/sim_pfa_dft_engine.sv
module sim_pfa_dft_engine;

  localparam int OW  = 22;
  localparam int TOL = 16;

  logic clk, rst_n, start, busy, done, ld_en;
  logic [1:0] len_sel;
  logic [3:0] ld_addr, rd_addr;
  logic signed [15:0] ld_re, ld_im;
  logic signed [OW-1:0] rd_re, rd_im;

  int total, bad;
  int xr[15], xi[15];
  bit finished;

  pfa_dft_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
    .busy(busy), .done(done), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_re(ld_re), .ld_im(ld_im), .rd_addr(rd_addr),
    .rd_re(rd_re), .rd_im(rd_im)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int f1(int c); return (c == 0) ? 2 : ((c == 1) ? 4 : 3); endfunction
  function automatic int f2(int c); return (c == 2) ? 5 : 3; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_one(int a, int re, int im);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 4'(a); ld_re = 16'(re); ld_im = 16'(im);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // R2 layout: address n2*N1+n1 holds x[(N2*n1+N1*n2) mod N]
  task automatic load_perm(int c);
    int n1c = f1(c), n2c = f2(c), nn = f1(c) * f2(c);
    for (int b = 0; b < n2c; b++)
      for (int a = 0; a < n1c; a++) begin
        int idx = (n2c * a + n1c * b) % nn;
        load_one(b * n1c + a, xr[idx], xi[idx]);
      end
  endtask

  task automatic run(int c, bit disturb);
    int n = 0;
    int t = f1(c) * f2(c) * (f1(c) + f2(c));
    @(negedge clk);
    start = 1'b1; len_sel = 2'(c);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    while (busy && n < 1000) begin
      n++;
      if (disturb && n == 3) begin
        start = 1'b1; len_sel = 2'd2;              // R5 ignored start
        ld_en = 1'b1; ld_addr = 4'd10; ld_re = 16'sd999; ld_im = 16'sd999; // R7
      end
      if (disturb && n == 4) begin
        start = 1'b0; ld_en = 1'b0;
      end
      @(negedge clk);
    end
    chk(n == t, disturb ? "R5" : "R4", "busy cycles", n, t);
    chk(done == 1'b1, "R4", "done with busy low", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R4", "done one cycle", int'(done), 0);
  endtask

  task automatic check_out(int c, string req);
    int nn = f1(c) * f2(c);
    for (int k = 0; k < nn; k++) begin
      real sr = 0.0, si = 0.0;
      for (int n = 0; n < nn; n++) begin
        real ang = -2.0 * 3.14159265358979 * real'(n * k) / real'(nn);
        sr += real'(xr[n]) * $cos(ang) - real'(xi[n]) * $sin(ang);
        si += real'(xr[n]) * $sin(ang) + real'(xi[n]) * $cos(ang);
      end
      rd_addr = 4'(k);
      #1;
      chk((int'(rd_re) - int'(sr) <= TOL) && (int'(sr) - int'(rd_re) <= TOL),
          req, "bin real", int'(rd_re), int'(sr));
      chk((int'(rd_im) - int'(si) <= TOL) && (int'(si) - int'(rd_im) <= TOL),
          req, "bin imag", int'(rd_im), int'(si));
    end
  endtask

  task automatic fill_rand(int c);
    for (int n = 0; n < f1(c) * f2(c); n++) begin
      xr[n] = int'($signed(16'($urandom)));
      xi[n] = int'($signed(16'($urandom)));
    end
  endtask

  initial begin
    int unused_seed;
    total = 0; bad = 0; finished = 1'b0;
    unused_seed = int'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; len_sel = 2'd0; ld_en = 1'b0;
    ld_addr = '0; ld_re = '0; ld_im = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8", "reset outputs", int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8", "after release", int'(busy) + int'(done), 0);

    // R9 sign-extended readback
    load_one(3, -5, 77);
    rd_addr = 4'd3; #1;
    chk(int'(rd_re) == -5, "R9", "readback real", int'(rd_re), -5);
    chk(int'(rd_im) == 77, "R9", "readback imag", int'(rd_im), 77);

    // impulse, every length: flat spectrum (R1, R2, R3)
    for (int c = 0; c < 3; c++) begin
      for (int n = 0; n < 15; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[0] = 20000; xi[0] = -3000;
      load_perm(c); run(c, 1'b0); check_out(c, "R3");
    end

    // full-scale negative constant, every length (R10)
    for (int c = 0; c < 3; c++) begin
      for (int n = 0; n < 15; n++) begin xr[n] = -32768; xi[n] = -32768; end
      load_perm(c); run(c, 1'b0); check_out(c, "R10");
    end

    // alternating extremes on length 15 (R10)
    for (int n = 0; n < 15; n++) begin
      xr[n] = (n % 2) ? 32767 : -32768;
      xi[n] = (n % 3) ? -32768 : 32767;
    end
    load_perm(2); run(2, 1'b0); check_out(2, "R10");

    // seeded random data across lengths (R3)
    for (int r = 0; r < 6; r++) begin
      int c = r % 3;
      fill_rand(c); load_perm(c); run(c, 1'b0); check_out(c, "R3");
    end

    // start and load during a run (R5, R7)
    fill_rand(0); load_perm(0);
    load_one(10, 1234, -77);
    run(0, 1'b1);
    check_out(0, "R5");
    rd_addr = 4'd10; #1;
    chk(int'(rd_re) == 1234, "R7", "spare real", int'(rd_re), 1234);
    chk(int'(rd_im) == -77, "R7", "spare imag", int'(rd_im), -77);

    // unsupported code (R6)
    begin
      int v_re, v_im;
      rd_addr = 4'd0; #1;
      v_re = int'(rd_re); v_im = int'(rd_im);
      @(negedge clk);
      start = 1'b1; len_sel = 2'd3;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 10; i++) begin
        chk(busy == 1'b0 && done == 1'b0, "R6", "stays idle", int'(busy) + int'(done), 0);
        @(negedge clk);
      end
      rd_addr = 4'd0; #1;
      chk(int'(rd_re) == v_re && int'(rd_im) == v_im, "R6", "memory kept", int'(rd_re), v_re);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule